// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is the configuration front end of a parallel-port logical device. A host bus talks to it through two byte-wide addresses: address 0 holds a register index, address 1 reads or writes the register that index selects. The register file stays hidden until a key byte has been written to the index address on two index writes in a row. A seal byte written to the index address hides it again.

Once the port is open, software selects the logical device, reads the identity registers, and programs activation, the I/O base address, the interrupt line, the DMA channel and a mode register. The block turns these fields into plain configuration outputs for the port datapath. While the port is closed every data access reads 0xFF, including the identity registers, so a probe that compares the locked and unlocked reads of the identity indexes can tell this device apart from an unrelated register that happens to answer.

Host accesses are single-cycle strobes with no back-pressure. A write takes effect at the clock edge where it is sampled. Read data is combinational from the current state while `bus_rd` is high, and is 0x00 otherwise.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the port is locked (`cfg_open`=0), `port_active`=0, `port_base`=0, `port_irq`=0, `dma_en`=0 with DMA field 4 (none), and `port_mode`, `fifo_thresh` and `irq_follow_ack` are all 0.
- R2: Two consecutive index writes (`bus_addr`=0) of KEY_BYTE (default 0x87) open the port, so `cfg_open` is 1 from the next cycle.
- R3: An index write of any other value after a single key write cancels the sequence; two further key writes are needed. Data-port accesses between the two key writes do not cancel it.
- R4: An index write of SEAL_BYTE (0xAA) while open closes the port in the next cycle and is not stored as an index.
- R5: While locked, every read at either address returns 0xFF (the identity indexes included), and data-port writes change no register and no output.
- R6: While open, an index read returns the current index. Index 0x20 reads DEV_ID (default 0x52) and index 0x21 reads DEV_REV (default 0xF1), and writes to both are ignored. An unmapped index reads 0xFF.
- R7: Index 0x07 is the logical device number (read/write, reset 0). The registers at 0x30, 0x60, 0x61, 0x70, 0x74 and 0xF0 are visible only when it equals PP_LDN (default 1). For any other device they read 0xFF and ignore writes.
- R8: Register 0x30 stores bit 0 only (other bits read 0) and drives `port_active`. Register 0x60 is `port_base[15:8]` and register 0x61 is `port_base[7:0]`.
- R9: Register 0x70 stores bits [3:0] only, which drive `port_irq`. Its upper bits read 0.
- R10: Register 0x74 stores bits [2:0] only. A value of 0 to 3 gives `dma_en`=1 and `dma_chan` equal to that value. A value of 4 to 7 gives `dma_en`=0 and `dma_chan`=0.
- R11: Register 0xF0 drives `port_mode` from bits [2:0], `fifo_thresh` from bits [6:3], and `irq_follow_ack` from bit 7 (1 = the interrupt follows the acknowledge line, 0 = pulsed). It reads back as written.
- R12: Configuration outputs keep their values when the port is sealed, and the registers read back unchanged after a later unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| cfg_open | output | 1 | Configuration space is unlocked |
| port_active | output | 1 | Parallel port enabled |
| port_base | output | 16 | I/O base address |
| port_irq | output | 4 | Interrupt line number |
| dma_en | output | 1 | A DMA channel is assigned |
| dma_chan | output | 2 | DMA channel number |
| port_mode | output | 3 | Port operating mode |
| fifo_thresh | output | 4 | FIFO threshold |
| irq_follow_ack | output | 1 | Interrupt follows the acknowledge line |

## Verification
The unlock logic is driven with a clean key pair, a key followed by a stray index value, a key with data-port traffic in the middle, a triple key, and a seal. Together these separate a two-in-a-row detector from one that counts keys in any order or that is reset by data accesses. The identity indexes are read both locked and open, which shows the hiding. Register tests use DMA values 3 and 4 to locate the edge of the none range. They set all bits of the DMA and IRQ registers to expose masking, and switch the logical device away from the parallel port to show that the device registers are gated.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] IX_LDN    = 8'h07;
  localparam logic [7:0] IX_ID     = 8'h20;
  localparam logic [7:0] IX_REV    = 8'h21;
  localparam logic [7:0] IX_ACT    = 8'h30;
  localparam logic [7:0] IX_BASEHI = 8'h60;
  localparam logic [7:0] IX_BASELO = 8'h61;
  localparam logic [7:0] IX_IRQ    = 8'h70;
  localparam logic [7:0] IX_DMA    = 8'h74;
  localparam logic [7:0] IX_MODE   = 8'hF0;

  localparam logic [2:0] DMA_NONE  = 3'd4;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfg_keyport_pkg::*;
#(
  parameter logic [BYTE_W-1:0] KEY_BYTE  = 8'h87,
  parameter logic [BYTE_W-1:0] SEAL_BYTE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              open
);
  key_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        KS_LOCKED: state_d = (wdata == KEY_BYTE) ? KS_HALF : KS_LOCKED;
        KS_HALF:   state_d = (wdata == KEY_BYTE) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   state_d = (wdata == SEAL_BYTE) ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_keyport_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SEAL_BYTE = 8'hAA,
  parameter logic [BYTE_W-1:0] DEV_ID    = 8'h52,
  parameter logic [BYTE_W-1:0] DEV_REV   = 8'hF1,
  parameter logic [BYTE_W-1:0] PP_LDN    = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic              idx_wr,
  input  logic              dat_wr,
  input  logic              rd,
  input  logic              rd_data_port,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              r_act,
  output logic [BYTE_W-1:0] r_base_hi,
  output logic [BYTE_W-1:0] r_base_lo,
  output logic [3:0]        r_irq,
  output logic [2:0]        r_dma,
  output logic [BYTE_W-1:0] r_mode
);
  localparam logic [BYTE_W-1:0] ALL_ONES = '1;

  logic [BYTE_W-1:0] index_q;
  logic [BYTE_W-1:0] ldn_q;
  logic              dev_sel;
  logic              wr_ok;
  logic [BYTE_W-1:0] sel_val;

  assign dev_sel = (ldn_q == PP_LDN);
  assign wr_ok   = open && dat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q   <= '0;
      ldn_q     <= '0;
      r_act     <= 1'b0;
      r_base_hi <= '0;
      r_base_lo <= '0;
      r_irq     <= '0;
      r_dma     <= DMA_NONE;
      r_mode    <= '0;
    end else begin
      if (open && idx_wr && (wdata != SEAL_BYTE)) index_q <= wdata;
      if (wr_ok) begin
        if (index_q == IX_LDN) ldn_q <= wdata;
        if (dev_sel) begin
          unique case (index_q)
            IX_ACT:    r_act     <= wdata[0];
            IX_BASEHI: r_base_hi <= wdata;
            IX_BASELO: r_base_lo <= wdata;
            IX_IRQ:    r_irq     <= wdata[3:0];
            IX_DMA:    r_dma     <= wdata[2:0];
            IX_MODE:   r_mode    <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    sel_val = ALL_ONES;
    unique case (index_q)
      IX_LDN: sel_val = ldn_q;
      IX_ID:  sel_val = DEV_ID;
      IX_REV: sel_val = DEV_REV;
      IX_ACT:    if (dev_sel) sel_val = {{(BYTE_W-1){1'b0}}, r_act};
      IX_BASEHI: if (dev_sel) sel_val = r_base_hi;
      IX_BASELO: if (dev_sel) sel_val = r_base_lo;
      IX_IRQ:    if (dev_sel) sel_val = {{(BYTE_W-4){1'b0}}, r_irq};
      IX_DMA:    if (dev_sel) sel_val = {{(BYTE_W-3){1'b0}}, r_dma};
      IX_MODE:   if (dev_sel) sel_val = r_mode;
      default: ;
    endcase
  end

  always_comb begin
    if (!rd)                rdata = '0;
    else if (!open)         rdata = ALL_ONES;
    else if (rd_data_port)  rdata = sel_val;
    else                    rdata = index_q;
  end
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import cfg_keyport_pkg::*;
(
  input  logic              r_act,
  input  logic [BYTE_W-1:0] r_base_hi,
  input  logic [BYTE_W-1:0] r_base_lo,
  input  logic [3:0]        r_irq,
  input  logic [2:0]        r_dma,
  input  logic [BYTE_W-1:0] r_mode,
  output logic              port_active,
  output logic [2*BYTE_W-1:0] port_base,
  output logic [3:0]        port_irq,
  output logic              dma_en,
  output logic [1:0]        dma_chan,
  output logic [2:0]        port_mode,
  output logic [3:0]        fifo_thresh,
  output logic              irq_follow_ack
);
  assign port_active    = r_act;
  assign port_base      = {r_base_hi, r_base_lo};
  assign port_irq       = r_irq;
  assign dma_en         = ~r_dma[2];
  assign dma_chan       = r_dma[2] ? 2'd0 : r_dma[1:0];
  assign port_mode      = r_mode[2:0];
  assign fifo_thresh    = r_mode[6:3];
  assign irq_follow_ack = r_mode[7];
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
  import cfg_keyport_pkg::*;
#(
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] SEAL_BYTE = 8'hAA,
  parameter logic [7:0] DEV_ID    = 8'h52,
  parameter logic [7:0] DEV_REV   = 8'hF1,
  parameter logic [7:0] PP_LDN    = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        cfg_open,
  output logic        port_active,
  output logic [15:0] port_base,
  output logic [3:0]  port_irq,
  output logic        dma_en,
  output logic [1:0]  dma_chan,
  output logic [2:0]  port_mode,
  output logic [3:0]  fifo_thresh,
  output logic        irq_follow_ack
);
  logic       idx_wr, dat_wr;
  logic       r_act;
  logic [7:0] r_base_hi, r_base_lo, r_mode;
  logic [3:0] r_irq;
  logic [2:0] r_dma;

  assign idx_wr = bus_wr && !bus_addr;
  assign dat_wr = bus_wr &&  bus_addr;

  cfg_unlock_fsm #(.KEY_BYTE(KEY_BYTE), .SEAL_BYTE(SEAL_BYTE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(bus_wdata), .open(cfg_open)
  );

  cfg_regfile #(.SEAL_BYTE(SEAL_BYTE), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .PP_LDN(PP_LDN)) u_regs (
    .clk(clk), .rst_n(rst_n), .open(cfg_open), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .rd(bus_rd), .rd_data_port(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .r_act(r_act), .r_base_hi(r_base_hi), .r_base_lo(r_base_lo),
    .r_irq(r_irq), .r_dma(r_dma), .r_mode(r_mode)
  );

  cfg_field_decode u_dec (
    .r_act(r_act), .r_base_hi(r_base_hi), .r_base_lo(r_base_lo),
    .r_irq(r_irq), .r_dma(r_dma), .r_mode(r_mode),
    .port_active(port_active), .port_base(port_base), .port_irq(port_irq),
    .dma_en(dma_en), .dma_chan(dma_chan), .port_mode(port_mode),
    .fifo_thresh(fifo_thresh), .irq_follow_ack(irq_follow_ack)
  );
endmodule

// File: rtl/cfg_keyport_chk.sv
module cfg_keyport_chk #(
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] SEAL_BYTE = 8'hAA
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        cfg_open,
  input logic        port_active,
  input logic [15:0] port_base,
  input logic [3:0]  port_irq,
  input logic        dma_en,
  input logic [1:0]  dma_chan
);
  AST_LOCKED_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_rd) |-> (bus_rdata == 8'hFF)); // R5

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == KEY_BYTE)); // R2

  AST_SEAL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_wr && !bus_addr && bus_wdata == SEAL_BYTE) |=> !cfg_open); // R4

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_wr && bus_addr) |=>
      ($stable(port_active) && $stable(port_base) && $stable(port_irq) && $stable(dma_en))); // R5

  AST_NO_CHAN_WITHOUT_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> (dma_chan == 2'd0)); // R10

  AST_SEAL_KEEPS_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> ($stable(port_base) && $stable(port_active) && $stable(port_irq))); // R12
endmodule

bind cfg_keyport cfg_keyport_chk #(.KEY_BYTE(KEY_BYTE), .SEAL_BYTE(SEAL_BYTE)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open),
  .port_active(port_active), .port_base(port_base), .port_irq(port_irq),
  .dma_en(dma_en), .dma_chan(dma_chan)
);

// File: tb/test_cfg_keyport.sv
module test_cfg_keyport;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] KEY  = 8'h87;
  localparam logic [7:0] SEAL = 8'hAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cfg_open, port_active, dma_en, irq_follow_ack;
  logic [15:0] port_base;
  logic [3:0] port_irq, fifo_thresh;
  logic [1:0] dma_chan;
  logic [2:0] port_mode;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_keyport i_cfg_keyport (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open),
    .port_active(port_active), .port_base(port_base), .port_irq(port_irq),
    .dma_en(dma_en), .dma_chan(dma_chan), .port_mode(port_mode),
    .fifo_thresh(fifo_thresh), .irq_follow_ack(irq_follow_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one write cycle; returns at the following falling edge
  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic unlock();
    wr(1'b0, KEY); wr(1'b0, KEY);
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    wr(1'b0, ix); wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
    wr(1'b0, ix); rd(1'b1, d);
  endtask

  task automatic t_reset();
    check("R1 open", cfg_open, 0);
    check("R1 active", port_active, 0);
    check("R1 base", port_base, 0);
    check("R1 irq", port_irq, 0);
    check("R1 dma_en", dma_en, 0);
    check("R1 mode", {irq_follow_ack, fifo_thresh, port_mode}, 0);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    rd(1'b1, v); check("R5 locked data read", v, 8'hFF);
    rd(1'b0, v); check("R5 locked index read", v, 8'hFF);
    wr(1'b0, 8'h20); rd(1'b1, v); check("R5 locked id read", v, 8'hFF);
    wr(1'b1, 8'h5A); check("R5 locked write", port_base, 0);
  endtask

  task automatic t_sequence();
    wr(1'b0, KEY); check("R2 one key", cfg_open, 0);
    wr(1'b0, 8'h20); wr(1'b0, KEY); check("R3 broken seq", cfg_open, 0);
    wr(1'b0, KEY); check("R2 two keys", cfg_open, 1);
    wr(1'b0, SEAL); check("R4 sealed", cfg_open, 0);
    wr(1'b0, KEY); wr(1'b1, 8'h11); wr(1'b0, KEY);
    check("R3 data access keeps seq", cfg_open, 1);
    wr(1'b0, SEAL);
    wr(1'b0, KEY); wr(1'b0, KEY); wr(1'b0, KEY);
    check("R2 third key stays open", cfg_open, 1);
  endtask

  task automatic t_ident();
    logic [7:0] v;
    wr(1'b0, 8'h21); rd(1'b0, v); check("R6 index readback", v, 8'h21);
    reg_rd(8'h20, v); check("R6 id", v, 8'h52);
    reg_rd(8'h21, v); check("R6 rev", v, 8'hF1);
    reg_wr(8'h20, 8'h00); reg_rd(8'h20, v); check("R6 id write ignored", v, 8'h52);
    reg_rd(8'h55, v); check("R6 unmapped", v, 8'hFF);
    wr(1'b0, SEAL); wr(1'b0, KEY); wr(1'b0, KEY);
    rd(1'b0, v); check("R4 seal not stored as index", v, 8'h55);
  endtask

  task automatic t_ldn();
    logic [7:0] v;
    reg_rd(8'h07, v); check("R7 ldn reset", v, 0);
    reg_rd(8'h60, v); check("R7 hidden reg", v, 8'hFF);
    reg_wr(8'h60, 8'h12); check("R7 hidden write", port_base, 0);
    reg_wr(8'h07, 8'h01); reg_rd(8'h07, v); check("R7 ldn rw", v, 8'h01);
  endtask

  task automatic t_fields();
    logic [7:0] v;
    reg_wr(8'h30, 8'hFF); check("R8 active", port_active, 1);
    reg_rd(8'h30, v); check("R8 act mask", v, 8'h01);
    reg_wr(8'h60, 8'h03); reg_wr(8'h61, 8'h78); check("R8 base", port_base, 16'h0378);
    reg_wr(8'h70, 8'hF7); check("R9 irq", port_irq, 4'h7);
    reg_rd(8'h70, v); check("R9 irq mask", v, 8'h07);
    reg_wr(8'h74, 8'h03); check("R10 dma3 en", dma_en, 1); check("R10 dma3 chan", dma_chan, 3);
    reg_wr(8'h74, 8'h04); check("R10 dma4 none", dma_en, 0); check("R10 dma4 chan", dma_chan, 0);
    reg_wr(8'h74, 8'hF9); check("R10 dma mask en", dma_en, 1); check("R10 dma mask chan", dma_chan, 1);
    reg_rd(8'h74, v); check("R10 dma readback", v, 8'h01);
    reg_wr(8'hF0, 8'hD5);
    check("R11 mode", port_mode, 3'd5);
    check("R11 thresh", fifo_thresh, 4'hA);
    check("R11 irq type", irq_follow_ack, 1);
    reg_rd(8'hF0, v); check("R11 readback", v, 8'hD5);
  endtask

  task automatic t_persist();
    logic [7:0] v;
    wr(1'b0, SEAL);
    check("R12 base kept", port_base, 16'h0378);
    check("R12 active kept", port_active, 1);
    unlock();
    reg_rd(8'h61, v); check("R12 readback", v, 8'h78);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_sequence();
    t_ident();
    t_ldn();
    t_fields();
    t_persist();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule